// File: doc/BRIEF.md
# Scanline Interrupt Counter with Frame-Active Tracking

This block counts the scanlines a picture generator renders. When the running count equals a compare value set by the CPU, it raises an interrupt. Two inputs describe the video side:
- a one-cycle strobe that marks each scanline change;
- a level that is high while rendering is active, meaning the visible field with background or sprites enabled.

The CPU sees two byte-wide registers, chosen by a single select bit:
- select 0 is the write-only compare register;
- select 1 is the control register on writes and the status register on reads.

A frame-active flag tracks whether the counter is running inside a frame. The first scanline change after rendering begins starts a new frame: it zeroes the counter and drops any old request. Each later scanline change advances the count.

Reading the status register acknowledges a pending request. The interrupt line is active low. It reflects the pending flag gated by the enable bit, with no added register stage.

Top module: `scanline_irq`

## Requirements
- R1: A write with `cpu_sel`=0 stores `cpu_wdata` as the compare value. It is used from the next cycle on.
- R2: A write with `cpu_sel`=1 sets the interrupt enable from `cpu_wdata[7]`, where 1 enables.
- R3: A read with `cpu_sel`=1 returns the pending flag in bit 7 and the frame-active flag in bit 6 in the same cycle, and clears the pending flag at the clock edge.
- R4: While `render_on` is low, the frame-active flag clears, line strobes are ignored, and the pending flag keeps its value.
- R5: A line strobe with `render_on` high and the frame-active flag clear sets the frame-active flag, zeroes the count and clears the pending flag.
- R6: A line strobe with `render_on` high and the frame-active flag set increments the count. If the new count equals the compare value, the pending flag is set.
- R7: `irq_n` is low exactly in the cycles where the pending flag and the enable are both 1.
- R8: Reset clears the compare value, enable, pending flag, frame-active flag and count, so `irq_n` is 1 and a status read returns 0.
- R9: Clearing the enable raises `irq_n` without clearing the pending flag. Setting the enable again drives `irq_n` low once more.
- R10: When a status read and a compare match fall in the same cycle, the pending flag ends up set.
- R11: Status bits 5:0 read as 0. `cpu_rdata` is 0 in every cycle that is not a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | One-cycle pulse per scanline change |
| render_on | input | 1 | High while rendering is active |
| cpu_we | input | 1 | CPU register write |
| cpu_re | input | 1 | CPU register read |
| cpu_sel | input | 1 | Register select: 0 compare, 1 control/status |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench sets a match and a status read in the same cycle. A design that lets the acknowledge win would lose that interrupt.

It turns the enable off and back on while a request is pending. A design that cleared the pending flag on disable would never drive the line low again.

It drops `render_on` with a request still pending and sends strobes during that gap. It then checks that the next frame restarts the count from zero. A design that kept counting would match one line early, and one that ignored the frame start would keep a stale request.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic {
    SEL_CMP  = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic pending;
    logic in_frame;
  } irq_state_t;
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
  import scanline_irq_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  localparam int unsigned EN_BIT = DATA_W - 1,
  localparam int unsigned PAD_W  = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic              cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  irq_state_t        st,
  output logic [DATA_W-1:0] cmp_val,
  output logic              irq_en,
  output logic              ack,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic wr_cmp, wr_ctrl;

  assign wr_cmp  = cpu_we && (reg_sel_e'(cpu_sel) == SEL_CMP);
  assign wr_ctrl = cpu_we && (reg_sel_e'(cpu_sel) == SEL_CTRL);
  assign ack     = cpu_re && (reg_sel_e'(cpu_sel) == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '0;
      irq_en  <= 1'b0;
    end else begin
      if (wr_cmp)  cmp_val <= cpu_wdata;
      if (wr_ctrl) irq_en  <= cpu_wdata[EN_BIT];
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (ack) cpu_rdata = {st.pending, st.in_frame, {PAD_W{1'b0}}};
  end

  p_cmp_wr_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && !cpu_sel) |=> cmp_val == $past(cpu_wdata));
  p_enable_wr_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_sel) |=> irq_en == $past(cpu_wdata[EN_BIT]));
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_strobe,
  input  logic             render_on,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ack,
  output logic             pending,
  output logic             in_frame
);
  logic [CNT_W-1:0] cnt, cnt_inc;
  logic             line_ev, frame_start, hit;

  assign line_ev     = render_on && line_strobe;
  assign frame_start = line_ev && !in_frame;
  assign cnt_inc     = cnt + 1'b1;
  assign hit         = line_ev && in_frame && (cnt_inc == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt      <= '0;
    end else if (!render_on) begin
      in_frame <= 1'b0;
    end else if (line_strobe) begin
      if (!in_frame) begin
        in_frame <= 1'b1;
        cnt      <= '0;
      end else begin
        cnt <= cnt_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      pending <= 1'b0;
    else if (hit)                 pending <= 1'b1;
    else if (ack || frame_start)  pending <= 1'b0;
  end

  p_inactive_clears_r4: assert property (@(posedge clk) disable iff (rst)
    !render_on |=> !in_frame);
  p_inactive_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (!render_on && !ack) |=> pending == $past(pending));
  p_frame_start_r5: assert property (@(posedge clk) disable iff (rst)
    (render_on && line_strobe && !in_frame) |=> (in_frame && !pending));
  p_pend_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(render_on && line_strobe && in_frame));
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (ack && !(render_on && line_strobe && in_frame)) |=> !pending);
  p_match_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && render_on && line_strobe && in_frame && (cnt + 1'b1 == cmp_val)) |=> pending);
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq
  import scanline_irq_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_strobe,
  input  logic              render_on,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic              cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_n
);
  irq_state_t        st;
  logic [DATA_W-1:0] cmp_val;
  logic              irq_en, ack;

  sirq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .st(st), .cmp_val(cmp_val), .irq_en(irq_en),
    .ack(ack), .cpu_rdata(cpu_rdata)
  );

  sirq_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .render_on(render_on),
    .cmp_val(cmp_val), .ack(ack), .pending(st.pending), .in_frame(st.in_frame)
  );

  // R7: both sources are registers, so the line follows them with no extra stage
  assign irq_n = ~(st.pending & irq_en);

  p_disable_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_sel && !cpu_wdata[DATA_W-1] && !cpu_re && !render_on && !irq_n) |=> (irq_n && st.pending));
endmodule

// File: tb/tb_scanline_irq.sv
module tb_scanline_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_strobe = 1'b0, render_on = 1'b0;
  logic       cpu_we = 1'b0, cpu_re = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       irq_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic       irq_n;
    logic [7:0] rdata;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Expected-state model built from the requirements
  logic       m_pend = 0, m_inf = 0, m_en = 0;
  logic [7:0] m_cnt = 0, m_cmp = 0;

  always #10 clk = ~clk;

  scanline_irq dut (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .render_on(render_on),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_n(irq_n)
  );

  task automatic step(input logic s, input logic r, input logic we, input logic re,
                      input logic sel, input logic [7:0] wd, input string tag);
    exp_t e;
    logic set_now, fstart;
    @(negedge clk);
    line_strobe = s; render_on = r; cpu_we = we; cpu_re = re; cpu_sel = sel; cpu_wdata = wd;
    e.irq_n = !(m_pend && m_en);
    e.rdata = (re && sel) ? {m_pend, m_inf, 6'b0} : 8'h00;
    e.tag   = tag;
    sb.push_back(e);
    @(posedge clk);
    set_now = r && s && m_inf && (8'(m_cnt + 1) == m_cmp);
    fstart  = r && s && !m_inf;
    if (!r) m_inf = 0;
    else if (s) begin
      if (!m_inf) begin m_inf = 1; m_cnt = 0; end
      else m_cnt = 8'(m_cnt + 1);
    end
    if (set_now) m_pend = 1;
    else if ((re && sel) || fstart) m_pend = 0;
    if (we && !sel) m_cmp = wd;
    if (we && sel)  m_en = wd[7];
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_run++;
        if (irq_n !== e.irq_n || cpu_rdata !== e.rdata) begin
          n_fail++;
          $display("FAIL %s: irq_n=%b rdata=%h expected irq_n=%b rdata=%h",
                   e.tag, irq_n, cpu_rdata, e.irq_n, e.rdata);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    step(0,1,0,1,1,8'h00,"R8 reset status");
    step(0,1,0,0,0,8'h00,"R11 idle rdata");
    step(0,1,1,0,0,8'd3,"R1 write compare");
    step(0,1,1,0,1,8'h80,"R2 enable");
    step(1,1,0,0,0,8'h00,"R5 frame start");
    step(0,1,0,1,1,8'h00,"R5 in-frame status");
    step(1,1,0,0,0,8'h00,"R6 line 1");
    step(1,1,0,0,0,8'h00,"R6 line 2");
    step(1,1,0,0,0,8'h00,"R6 line 3 match");
    step(0,1,0,0,0,8'h00,"R7 irq asserted");
    step(0,1,1,0,1,8'h00,"R9 disable");
    step(0,1,0,0,0,8'h00,"R9 hidden");
    step(0,1,1,0,1,8'h80,"R9 re-enable");
    step(0,1,0,0,0,8'h00,"R9 reasserted");
    step(0,1,0,1,1,8'h00,"R3 status read");
    step(0,1,0,0,0,8'h00,"R3 acknowledged");
    step(0,1,0,1,0,8'h00,"R11 compare read zero");
    step(0,1,1,0,0,8'd5,"R1 compare 5");
    step(1,1,0,0,0,8'h00,"R6 line 4");
    step(1,1,0,1,1,8'h00,"R10 match with read");
    step(0,1,0,1,1,8'h00,"R10 pending kept");
    step(0,1,0,0,0,8'h00,"R3 cleared");
    step(0,1,1,0,0,8'd2,"R1 compare 2");
    step(0,0,0,0,0,8'h00,"R4 render off");
    step(1,0,0,0,0,8'h00,"R4 strobe ignored");
    step(0,1,0,1,1,8'h00,"R4 in-frame cleared");
    step(1,1,0,0,0,8'h00,"R5 new frame");
    step(1,1,0,0,0,8'h00,"R6 line 1");
    step(1,1,0,0,0,8'h00,"R6 line 2 match");
    step(0,0,0,0,0,8'h00,"R7 pending asserted");
    step(1,0,0,0,0,8'h00,"R4 pending kept");
    step(0,1,0,0,0,8'h00,"R4 still pending");
    step(1,1,0,0,0,8'h00,"R5 frame start");
    step(0,1,0,1,1,8'h00,"R5 pending cleared");
    step(1,1,0,0,0,8'h00,"R6 count from zero");
    step(0,1,0,1,1,8'h00,"R6 not yet");
    step(1,1,0,0,0,8'h00,"R6 second line");
    step(0,1,0,1,1,8'h00,"R3 read after match");
    step(0,1,0,0,0,8'h00,"R7 line released");
    @(negedge clk); #5;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule